// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the accumulator datapath of a small 8-bit processor core. Each cycle in which `valid_i` is high, it decodes one opcode byte, combines the internally held accumulator with the operand byte supplied by the surrounding core, and updates the accumulator and the status flag byte. Operand fetch, sequencing, the general register file and 16-bit work stay in the core. For register-source forms the core places the selected register's value, or the accumulator's own value for the accumulator source, on `operand_i`.

The covered instructions are the eight register/immediate arithmetic and logic operations, the four accumulator rotates, decimal adjust after addition, complement accumulator, set carry and complement carry. Every other opcode leaves the state untouched. `acc_we_o` tells the core, in the same cycle, whether the presented instruction writes the accumulator.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator reads 00h and the flag byte reads 02h; neither changes in a cycle where `valid_i` is low.
- R2: For opcodes 80h-BFh bits 5:3 choose the operation (000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare), with the operand always taken from `operand_i`; opcodes C6h, CEh, D6h, DEh, E6h, EEh, F6h, FEh select the same eight operations through bits 5:3.
- R3: Add and add-with-carry write the 8-bit sum (plus the old carry for the carry form) and set carry from the carry out of bit 7 and auxiliary carry from the carry out of bit 3.
- R4: Subtract and subtract-with-borrow write the accumulator minus the operand (minus the old carry for the borrow form); carry is set when a borrow occurs, and auxiliary carry is the carry out of bit 3 of the internal sum of the accumulator, the ones' complement of the operand and the inverted borrow-in.
- R5: AND, XOR and OR write the bitwise result and clear both carry and auxiliary carry.
- R6: Compare sets the flags exactly as subtract would, leaves the accumulator unchanged and deasserts `acc_we_o`.
- R7: Opcode 07h rotates left with bit 7 into bit 0 and carry; 0Fh rotates right with bit 0 into bit 7 and carry; 17h rotates left with the old carry into bit 0 and bit 7 into carry; 1Fh rotates right with the old carry into bit 7 and bit 0 into carry; no flag other than carry changes.
- R8: Opcode 27h adds 06h when the low nibble exceeds 9 or auxiliary carry is set, then adds 60h when the resulting high nibble exceeds 9, the old carry is set or the first step carried out; carry becomes the old carry ORed with any carry out, auxiliary carry is the carry out of bit 3 of the first step.
- R9: Opcode 2Fh inverts the accumulator with flags unchanged; 37h sets carry; 3Fh inverts carry; the latter two leave the accumulator and all other flags unchanged.
- R10: After any write of flags from a result, sign equals result bit 7, zero is 1 for a zero result and parity is 1 for an even count of ones.
- R11: Flag byte layout is bit 7 sign, bit 6 zero, bit 4 auxiliary carry, bit 2 parity, bit 0 carry; bits 5 and 3 always read 0 and bit 1 always reads 1.
- R12: `acc_we_o` is high exactly when `valid_i` is high and the opcode writes the accumulator.
- R13: Opcodes outside the listed set change neither the accumulator nor the flags and keep `acc_we_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the presented instruction this cycle |
| opcode_i | input | 8 | Instruction opcode byte |
| operand_i | input | 8 | Register or immediate operand byte |
| acc_we_o | output | 1 | Presented instruction writes the accumulator |
| acc_o | output | 8 | Registered accumulator |
| flags_o | output | 8 | Registered flag byte |

## Verification
The assertions watch every cycle for the idle hold of both registers, the constant flag bits, the cleared carries after a logic operation, the untouched accumulator after compare, the flags other than carry surviving a rotate, and the exact inversion done by complement. Numerical results, borrow and auxiliary-carry edge cases, every decimal-adjust path and the parity of specific values can only be shown by the bench's chained instruction sequence, where each step starts from the state the previous one left.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;

  localparam int FL_S   = 7;
  localparam int FL_Z   = 6;
  localparam int FL_AC  = 4;
  localparam int FL_P   = 2;
  localparam int FL_ONE = 1;
  localparam int FL_C   = 0;
  localparam logic [DW-1:0] FL_RESET = 8'h02;

  typedef enum logic [2:0] {
    K_NONE, K_ALU, K_ROT, K_DAA, K_CMA, K_STC, K_CMC
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] sel;
  } ctrl_t;

  function automatic logic [DW-1:0] mk_flags(input logic [DW-1:0] r,
                                             input logic ac, input logic cy);
    logic [DW-1:0] f;
    f         = '0;
    f[FL_S]   = r[DW-1];
    f[FL_Z]   = (r == '0);
    f[FL_AC]  = ac;
    f[FL_P]   = ~^r;
    f[FL_ONE] = 1'b1;
    f[FL_C]   = cy;
    return f;
  endfunction
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] opcode_i,
  output ctrl_t         ctrl_o
);
  always_comb begin
    ctrl_o = '{kind: K_NONE, sel: 3'd0};
    if (opcode_i[7:6] == 2'b10) begin
      ctrl_o = '{kind: K_ALU, sel: opcode_i[5:3]};
    end else if (opcode_i[7:6] == 2'b11 && opcode_i[2:0] == 3'b110) begin
      ctrl_o = '{kind: K_ALU, sel: opcode_i[5:3]};
    end else if (opcode_i[7:6] == 2'b00 && opcode_i[2:0] == 3'b111) begin
      unique case (opcode_i[5:3])
        3'd4:    ctrl_o = '{kind: K_DAA, sel: 3'd0};
        3'd5:    ctrl_o = '{kind: K_CMA, sel: 3'd0};
        3'd6:    ctrl_o = '{kind: K_STC, sel: 3'd0};
        3'd7:    ctrl_o = '{kind: K_CMC, sel: 3'd0};
        default: ctrl_o = '{kind: K_ROT, sel: {1'b0, opcode_i[4:3]}};
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,   // carry (add) or borrow (sub) in
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,   // carry (add) or borrow (sub) out
  output logic          ac_o
);
  logic [DW-1:0] b_eff;
  logic          cin;
  logic [DW:0]   full;
  logic [NW:0]   low;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    cin   = sub_i ? ~cy_i : cy_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    low   = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin};
    res_o = full[DW-1:0];
    cy_o  = sub_i ? ~full[DW] : full[DW];
    ac_o  = low[NW];
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o
);
  localparam logic [NW-1:0] NIB_MAX = NW'(9);
  localparam logic [NW:0]   LO_FIX  = (NW+1)'(6);
  localparam logic [DW:0]   HI_FIX  = (DW+1)'(8'h60);

  logic          lo_need, hi_need;
  logic [NW:0]   lo_nib;
  logic [DW:0]   lo_sum, hi_sum;

  always_comb begin
    lo_need = (a_i[NW-1:0] > NIB_MAX) || ac_i;
    lo_nib  = {1'b0, a_i[NW-1:0]} + (lo_need ? LO_FIX : '0);
    lo_sum  = {1'b0, a_i} + (lo_need ? (DW+1)'(6) : '0);
    hi_need = (lo_sum[DW-1:NW] > NIB_MAX) || cy_i || lo_sum[DW];
    hi_sum  = {1'b0, lo_sum[DW-1:0]} + (hi_need ? HI_FIX : '0);
    res_o   = hi_sum[DW-1:0];
    cy_o    = cy_i | lo_sum[DW] | hi_sum[DW];
    ac_o    = lo_nib[NW];
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
(
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] f_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] flags_o,
  output logic          acc_wr_o,
  output logic          flag_wr_o
);
  logic          is_sub, cy_in;
  logic [DW-1:0] as_res, dj_res, lg_res;
  logic          as_cy, as_ac, dj_cy, dj_ac;

  // sel 2,3 subtract; 7 compare subtracts without borrow-in
  assign is_sub = (ctrl_i.sel[2:1] == 2'b01) || (ctrl_i.sel == 3'd7);
  assign cy_in  = !ctrl_i.sel[2] && ctrl_i.sel[0] && f_i[FL_C];

  acc_alu_addsub u_addsub (
    .a_i(a_i), .b_i(b_i), .cy_i(cy_in), .sub_i(is_sub),
    .res_o(as_res), .cy_o(as_cy), .ac_o(as_ac)
  );

  acc_alu_decadj u_decadj (
    .a_i(a_i), .cy_i(f_i[FL_C]), .ac_i(f_i[FL_AC]),
    .res_o(dj_res), .cy_o(dj_cy), .ac_o(dj_ac)
  );

  always_comb begin
    unique case (ctrl_i.sel[1:0])
      2'd0:    lg_res = a_i & b_i;
      2'd1:    lg_res = a_i ^ b_i;
      default: lg_res = a_i | b_i;
    endcase
  end

  always_comb begin
    res_o     = a_i;
    flags_o   = f_i;
    acc_wr_o  = 1'b0;
    flag_wr_o = 1'b0;
    unique case (ctrl_i.kind)
      K_ALU: begin
        flag_wr_o = 1'b1;
        if (ctrl_i.sel[2] && ctrl_i.sel != 3'd7) begin
          res_o    = lg_res;
          flags_o  = mk_flags(lg_res, 1'b0, 1'b0);
          acc_wr_o = 1'b1;
        end else begin
          flags_o = mk_flags(as_res, as_ac, as_cy);
          if (ctrl_i.sel != 3'd7) begin
            res_o    = as_res;
            acc_wr_o = 1'b1;
          end
        end
      end
      K_ROT: begin
        acc_wr_o  = 1'b1;
        flag_wr_o = 1'b1;
        unique case (ctrl_i.sel[1:0])
          2'd0: begin res_o = {a_i[DW-2:0], a_i[DW-1]};  flags_o[FL_C] = a_i[DW-1]; end
          2'd1: begin res_o = {a_i[0], a_i[DW-1:1]};     flags_o[FL_C] = a_i[0];    end
          2'd2: begin res_o = {a_i[DW-2:0], f_i[FL_C]};  flags_o[FL_C] = a_i[DW-1]; end
          default: begin res_o = {f_i[FL_C], a_i[DW-1:1]}; flags_o[FL_C] = a_i[0]; end
        endcase
      end
      K_DAA: begin
        res_o     = dj_res;
        flags_o   = mk_flags(dj_res, dj_ac, dj_cy);
        acc_wr_o  = 1'b1;
        flag_wr_o = 1'b1;
      end
      K_CMA: begin
        res_o    = ~a_i;
        acc_wr_o = 1'b1;
      end
      K_STC: begin
        flags_o[FL_C] = 1'b1;
        flag_wr_o     = 1'b1;
      end
      K_CMC: begin
        flags_o[FL_C] = ~f_i[FL_C];
        flag_wr_o     = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] opcode_i,
  input  logic [DW-1:0] operand_i,
  output logic          acc_we_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] flags_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] acc_q, flags_q, res, flags_nx;
  logic          acc_wr, flag_wr;

  acc_alu_decode u_decode (.opcode_i(opcode_i), .ctrl_o(ctrl));

  acc_alu_exec u_exec (
    .ctrl_i(ctrl), .a_i(acc_q), .b_i(operand_i), .f_i(flags_q),
    .res_o(res), .flags_o(flags_nx), .acc_wr_o(acc_wr), .flag_wr_o(flag_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= FL_RESET;
    end else if (valid_i) begin
      if (acc_wr)  acc_q   <= res;
      if (flag_wr) flags_q <= flags_nx;
    end
  end

  assign acc_we_o = valid_i & acc_wr;
  assign acc_o    = acc_q;
  assign flags_o  = flags_q;

  // opcode classes seen at the port, for the checks below
  logic op_alu_grp, op_logic, op_cmp, op_rot;
  assign op_alu_grp = (opcode_i[7:6] == 2'b10) ||
                      (opcode_i[7:6] == 2'b11 && opcode_i[2:0] == 3'b110);
  assign op_logic   = op_alu_grp && opcode_i[5] && opcode_i[5:3] != 3'b111;
  assign op_cmp     = op_alu_grp && opcode_i[5:3] == 3'b111;
  assign op_rot     = opcode_i[7:5] == 3'b000 && opcode_i[2:0] == 3'b111;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q) && $stable(flags_q)); // R1
  AST_FLAG_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_q[5] && !flags_q[3] && flags_q[FL_ONE]); // R11
  AST_LOGIC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_logic |=> !flags_q[FL_C] && !flags_q[FL_AC]); // R5
  AST_CMP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_cmp |=> $stable(acc_q)); // R6
  AST_ROT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_rot |=> $stable(flags_q[DW-1:1])); // R7
  AST_CMA_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i == 8'h2F |=> acc_q == ~$past(acc_q) && $stable(flags_q)); // R9
endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic       acc_we;
  logic [7:0] acc, flags;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  acc_alu i_acc_alu (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opcode),
    .operand_i(operand), .acc_we_o(acc_we), .acc_o(acc), .flags_o(flags)
  );

  // {opcode, operand, expected acc, expected flags, expected acc_we}; chained
  localparam int NV = 36;
  localparam logic [32:0] VEC [NV] = '{
    {8'hF6, 8'h35, 8'h35, 8'h06, 1'b1},  // R5 OR imm
    {8'hC6, 8'hCB, 8'h00, 8'h57, 1'b1},  // R3 add, carry, aux, zero
    {8'hCE, 8'h10, 8'h11, 8'h06, 1'b1},  // R3 add with carry
    {8'hD6, 8'h12, 8'hFF, 8'h87, 1'b1},  // R4 subtract borrow
    {8'hDE, 8'h0F, 8'hEF, 8'h82, 1'b1},  // R4 subtract with borrow
    {8'hFE, 8'hEF, 8'hEF, 8'h56, 1'b0},  // R6 compare equal
    {8'hFE, 8'hF0, 8'hEF, 8'h97, 1'b0},  // R6 compare below
    {8'h3F, 8'h00, 8'hEF, 8'h96, 1'b0},  // R9 CMC
    {8'h07, 8'h00, 8'hDF, 8'h97, 1'b1},  // R7 RLC
    {8'h3F, 8'h00, 8'hDF, 8'h96, 1'b0},  // R9 CMC
    {8'h17, 8'h00, 8'hBE, 8'h97, 1'b1},  // R7 RAL
    {8'h1F, 8'h00, 8'hDF, 8'h96, 1'b1},  // R7 RAR
    {8'h0F, 8'h00, 8'hEF, 8'h97, 1'b1},  // R7 RRC
    {8'h2F, 8'h00, 8'h10, 8'h97, 1'b1},  // R9 CMA
    {8'h3F, 8'h00, 8'h10, 8'h96, 1'b0},  // R9 CMC
    {8'h37, 8'h00, 8'h10, 8'h97, 1'b0},  // R9 STC
    {8'hA8, 8'h10, 8'h00, 8'h46, 1'b1},  // R5 XOR reg
    {8'hC6, 8'h38, 8'h38, 8'h02, 1'b1},  // R10 odd parity
    {8'hC6, 8'h45, 8'h7D, 8'h06, 1'b1},  // R3
    {8'h27, 8'h00, 8'h83, 8'h92, 1'b1},  // R8 low nibble fix
    {8'hE6, 8'h00, 8'h00, 8'h46, 1'b1},  // R5 AND imm
    {8'hC6, 8'h99, 8'h99, 8'h86, 1'b1},  // R10 sign
    {8'hCE, 8'h99, 8'h32, 8'h13, 1'b1},  // R3 carry and aux out
    {8'h27, 8'h00, 8'h98, 8'h83, 1'b1},  // R8 fix from aux and carry
    {8'hE6, 8'h00, 8'h00, 8'h46, 1'b1},  // R5
    {8'hF6, 8'hA0, 8'hA0, 8'h86, 1'b1},  // R5
    {8'h27, 8'h00, 8'h00, 8'h47, 1'b1},  // R8 high nibble fix, carry out
    {8'hB0, 8'h5A, 8'h5A, 8'h06, 1'b1},  // R2 OR reg
    {8'h97, 8'h5A, 8'h00, 8'h56, 1'b1},  // R2 subtract reg
    {8'h88, 8'hFF, 8'hFF, 8'h86, 1'b1},  // R2 add with carry reg
    {8'h37, 8'h00, 8'hFF, 8'h87, 1'b0},  // R9
    {8'h9F, 8'hFF, 8'hFF, 8'h87, 1'b1},  // R4 borrow in causes borrow
    {8'hB8, 8'h01, 8'hFF, 8'h92, 1'b0},  // R6 compare reg
    {8'h8F, 8'hFF, 8'hFE, 8'h93, 1'b1},  // R3 add with carry reg
    {8'hAD, 8'hFE, 8'h00, 8'h46, 1'b1},  // R5 XOR reg
    {8'h00, 8'h55, 8'h00, 8'h46, 1'b0}   // R13 unlisted opcode
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset acc", acc, 8'h00);
    chk("R1", "reset flags", flags, 8'h02);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      opcode  = VEC[i][32:25];
      operand = VEC[i][24:17];
      valid   = 1'b1;
      #1;
      chk("R12", $sformatf("acc_we vec%0d", i), {7'd0, acc_we}, {7'd0, VEC[i][0]});
      @(negedge clk);
      chk("R2", $sformatf("acc vec%0d", i), acc, VEC[i][16:9]);
      chk("R10", $sformatf("flags vec%0d", i), flags, VEC[i][8:1]);
    end

    // R1 idle cycle: strobe low, state holds
    opcode = 8'hC6; operand = 8'h01; valid = 1'b0;
    #1;
    chk("R12", "acc_we idle", {7'd0, acc_we}, 8'h00);
    @(negedge clk);
    chk("R1", "idle acc", acc, 8'h00);
    chk("R1", "idle flags", flags, 8'h46);

    // R13 more unlisted opcodes
    valid = 1'b1;
    foreach (VEC[k]) if (k < 3) begin
      opcode = (k == 0) ? 8'h76 : (k == 1) ? 8'hC3 : 8'h3E;
      operand = 8'hA5;
      #1;
      chk("R13", "unlisted acc_we", {7'd0, acc_we}, 8'h00);
      @(negedge clk);
      chk("R13", "unlisted acc", acc, 8'h00);
      chk("R13", "unlisted flags", flags, 8'h46);
    end

    // R11 fixed flag bits survive STC, then mid-run reset
    opcode = 8'h37; @(negedge clk);
    chk("R11", "fixed bits", flags & 8'h2A, 8'h02);
    valid = 1'b0;
    rst_n = 1'b0; #1;
    chk("R1", "async reset acc", acc, 8'h00);
    chk("R1", "async reset flags", flags, 8'h02);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule